// File: doc/BRIEF.md
# Waveform Capture and Playback Engine

This block moves sample streams between a data interface and one port of a simple dual-port block RAM. In capture mode it writes one input sample per clock into consecutive RAM words starting at word 0. In playback mode it reads consecutive words starting at word 0 and presents each word on an output interface, with a valid strobe. A processor reaches the other RAM port on its own path. It uses that path to preload playback data and to read back captured data.

Software drives the block through an AXI4-Lite slave. It picks a mode, programs a sample count, writes a trigger and then polls a status word until the done bit is set. A mode FSM has the states RESET, CAPTURE and PLAYBACK. Its transitions are RESET to CAPTURE, RESET to PLAYBACK, CAPTURE to RESET and PLAYBACK to RESET. A request to go straight from one working mode to the other therefore passes through RESET for one cycle. Each working mode owns a sub-FSM with the states IDLE, ACTIVE and DONE. Its transitions are: IDLE or DONE to ACTIVE on a trigger with a non-zero count; IDLE or DONE to DONE on a trigger with a zero count; ACTIVE to DONE on the last sample; and any state to IDLE while the mode FSM sits in RESET. Both sub-FSMs share one address counter and the single RAM port.

Top module: `wcap_engine`

## Requirements
- R1: Every AXI4-Lite write and read completes with response OKAY (2'b00). A write is accepted only when address and data are valid together. BVALID and RVALID stay high until the master takes them.
- R2: Word offset 0x0 is control. Bits [1:0] select the mode (0 reset, 1 capture, 2 playback, 3 treated as reset). Writing bit 2 as 1 issues a one-shot trigger, and bit 2 always reads back as 0. Offset 0x4 holds the sample count in ADDR_W+1 bits and reads back as written.
- R3: Offset 0x8 is a read-only status word. Bits [1:0] give the state of the sub-FSM of the current mode (0 IDLE, 1 ACTIVE, 2 DONE) and bit 2 is the done flag. Writes to 0x8 and to the unmapped offset 0xC change nothing, and a read of 0xC returns 0.
- R4: The mode FSM follows the mode field. Moving between capture and playback passes through RESET, and at most one sub-FSM is ACTIVE at any time.
- R5: A trigger starts work only while the mode FSM is in CAPTURE or PLAYBACK. In reset mode it produces no RAM access and the status stays 0.
- R6: A capture of N samples writes the input sample of each ACTIVE cycle to RAM words 0..N-1 in order, on consecutive cycles, and then enters DONE. No other word is written.
- R7: A playback of N samples reads RAM words 0..N-1 in order. The valid output rises one cycle after each read, and the data output carries that word. Exactly N valid beats occur.
- R8: A trigger with a count of 0 moves the sub-FSM straight to DONE without any RAM access.
- R9: A trigger while the sub-FSM is ACTIVE is ignored. A trigger in DONE restarts the run from word 0. The count is captured at the trigger.
- R10: Selecting reset mode returns both sub-FSMs to IDLE and clears the done flag, so a later return to a working mode reports IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awaddr | input | 4 | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write strobes (not used, full-word writes) |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | 4 | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| cap_data_i | input | DATA_W | Sample to capture, taken every ACTIVE capture cycle |
| pb_data_o | output | DATA_W | Played-back sample, zero when not valid |
| pb_valid_o | output | 1 | Played-back sample valid |
| ram_en_o | output | 1 | RAM port enable |
| ram_we_o | output | 1 | RAM port write enable |
| ram_addr_o | output | ADDR_W | RAM word address |
| ram_wdata_o | output | DATA_W | RAM write data |
| ram_rdata_i | input | DATA_W | RAM read data, one cycle after the read enable |

## Verification
The assertions assume an AXI4-Lite master that holds each valid and its payload until the handshake, and that presents write address and data in the same cycle. They also assume a RAM that returns read data exactly one cycle after an enabled read. The bench keeps to these rules: its bus tasks raise AWVALID and WVALID together and hold them until AWREADY, and its RAM model is a synchronous read array with a second port for preloading. Switching between working modes always happens several cycles before the next trigger, so the one RESET cycle on the way has completed when the trigger arrives.

// File: rtl/wcap_pkg.sv
package wcap_pkg;

    typedef enum logic [1:0] {
        SUB_IDLE   = 2'd0,
        SUB_ACTIVE = 2'd1,
        SUB_DONE   = 2'd2
    } sub_state_e;

    typedef enum logic [1:0] {
        M_RESET    = 2'd0,
        M_CAPTURE  = 2'd1,
        M_PLAYBACK = 2'd2
    } mode_state_e;

    localparam logic [1:0] MODE_CAP = 2'd1;
    localparam logic [1:0] MODE_PB  = 2'd2;

    localparam logic [1:0] WIDX_CTRL   = 2'd0;
    localparam logic [1:0] WIDX_COUNT  = 2'd1;
    localparam logic [1:0] WIDX_STATUS = 2'd2;

    localparam int unsigned SUB_CAP = 0;
    localparam int unsigned SUB_PB  = 1;
    localparam int unsigned N_SUB   = 2;

endpackage

// File: rtl/wcap_axil_regs.sv
module wcap_axil_regs
    import wcap_pkg::*;
#(
    parameter int unsigned CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       s_awaddr,
    input  logic             s_awvalid,
    output logic             s_awready,
    input  logic [31:0]      s_wdata,
    input  logic [3:0]       s_wstrb,
    input  logic             s_wvalid,
    output logic             s_wready,
    output logic [1:0]       s_bresp,
    output logic             s_bvalid,
    input  logic             s_bready,
    input  logic [3:0]       s_araddr,
    input  logic             s_arvalid,
    output logic             s_arready,
    output logic [31:0]      s_rdata,
    output logic [1:0]       s_rresp,
    output logic             s_rvalid,
    input  logic             s_rready,
    input  logic [2:0]       status_i,
    output logic [1:0]       mode_o,
    output logic [CNT_W-1:0] count_o,
    output logic             trig_o
);

    logic             wr_fire, rd_fire;
    logic [1:0]       wr_idx, rd_idx;
    logic [31:0]      rd_mux;
    logic [1:0]       mode_q;
    logic [CNT_W-1:0] count_q;
    logic             trig_q;
    logic             unused_bits;

    assign wr_idx      = s_awaddr[3:2];
    assign rd_idx      = s_araddr[3:2];
    assign s_awready   = s_awvalid && s_wvalid && !s_bvalid;
    assign s_wready    = s_awready;
    assign wr_fire     = s_awready;
    assign s_arready   = !s_rvalid;
    assign rd_fire     = s_arvalid && s_arready;
    assign s_bresp     = 2'b00;
    assign s_rresp     = 2'b00;
    assign unused_bits = ^{s_wstrb, s_awaddr[1:0], s_araddr[1:0], s_wdata[31:CNT_W]};

    always_comb begin
        unique case (rd_idx)
            WIDX_CTRL:   rd_mux = {30'd0, mode_q};
            WIDX_COUNT:  rd_mux = 32'(count_q);
            WIDX_STATUS: rd_mux = {29'd0, status_i};
            default:     rd_mux = 32'd0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= 2'd0;
            count_q  <= '0;
            trig_q   <= 1'b0;
            s_bvalid <= 1'b0;
            s_rvalid <= 1'b0;
            s_rdata  <= 32'd0;
        end else begin
            trig_q <= 1'b0;
            if (wr_fire) begin
                s_bvalid <= 1'b1;
                if (wr_idx == WIDX_CTRL) begin
                    mode_q <= s_wdata[1:0];
                    trig_q <= s_wdata[2];
                end else if (wr_idx == WIDX_COUNT) begin
                    count_q <= s_wdata[CNT_W-1:0];
                end
            end else if (s_bvalid && s_bready) begin
                s_bvalid <= 1'b0;
            end
            if (rd_fire) begin
                s_rvalid <= 1'b1;
                s_rdata  <= rd_mux;
            end else if (s_rvalid && s_rready) begin
                s_rvalid <= 1'b0;
            end
        end
    end

    assign mode_o  = mode_q;
    assign count_o = count_q;
    assign trig_o  = trig_q;

endmodule

// File: rtl/wcap_mode_fsm.sv
module wcap_mode_fsm
    import wcap_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  mode_req_i,
    output mode_state_e state_o,
    output logic        clr_o,
    output logic        cap_sel_o,
    output logic        pb_sel_o
);

    mode_state_e cur, nxt, target;

    always_comb begin
        if (mode_req_i == MODE_CAP)     target = M_CAPTURE;
        else if (mode_req_i == MODE_PB) target = M_PLAYBACK;
        else                            target = M_RESET;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur <= M_RESET;
        else        cur <= nxt;
    end

    always_comb begin
        nxt = cur;
        unique case (cur)
            M_RESET:    nxt = target;
            M_CAPTURE:  nxt = (target == M_CAPTURE)  ? M_CAPTURE  : M_RESET;
            M_PLAYBACK: nxt = (target == M_PLAYBACK) ? M_PLAYBACK : M_RESET;
            default:    nxt = M_RESET;
        endcase
    end

    always_comb begin
        clr_o     = (cur == M_RESET);
        cap_sel_o = (cur == M_CAPTURE);
        pb_sel_o  = (cur == M_PLAYBACK);
        state_o   = cur;
    end

endmodule

// File: rtl/wcap_sub_fsm.sv
module wcap_sub_fsm
    import wcap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_i,
    input  logic       sel_i,
    input  logic       trig_i,
    input  logic       zero_len_i,
    input  logic       last_i,
    output sub_state_e state_o,
    output logic       start_o,
    output logic       active_o
);

    sub_state_e cur, nxt;
    logic       go;

    always_ff @(posedge clk) begin
        if (!rst_n) cur <= SUB_IDLE;
        else        cur <= nxt;
    end

    always_comb begin
        nxt = cur;
        go  = 1'b0;
        unique case (cur)
            SUB_IDLE, SUB_DONE: begin
                if (sel_i && trig_i) begin
                    go  = 1'b1;
                    nxt = zero_len_i ? SUB_DONE : SUB_ACTIVE;
                end
            end
            SUB_ACTIVE: if (last_i) nxt = SUB_DONE;
            default:    nxt = SUB_IDLE;
        endcase
        if (clr_i) begin
            nxt = SUB_IDLE;
            go  = 1'b0;
        end
    end

    always_comb begin
        state_o  = cur;
        start_o  = go;
        active_o = (cur == SUB_ACTIVE);
    end

endmodule

// File: rtl/wcap_counter.sv
module wcap_counter #(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned CNT_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              start_i,
    input  logic              inc_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              last_o,
    output logic              zero_len_o
);

    logic [CNT_W-1:0] cnt_q, lim_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_q <= '0;
            lim_q <= '0;
        end else if (start_i) begin
            cnt_q <= '0;
            lim_q <= count_i;
        end else if (inc_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign addr_o     = cnt_q[ADDR_W-1:0];
    assign last_o     = (cnt_q == lim_q - CNT_W'(1));
    assign zero_len_o = (count_i == '0);

endmodule

// File: rtl/wcap_engine.sv
module wcap_engine
    import wcap_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        s_awaddr,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [31:0]       s_wdata,
    input  logic [3:0]        s_wstrb,
    input  logic              s_wvalid,
    output logic              s_wready,
    output logic [1:0]        s_bresp,
    output logic              s_bvalid,
    input  logic              s_bready,
    input  logic [3:0]        s_araddr,
    input  logic              s_arvalid,
    output logic              s_arready,
    output logic [31:0]       s_rdata,
    output logic [1:0]        s_rresp,
    output logic              s_rvalid,
    input  logic              s_rready,
    input  logic [DATA_W-1:0] cap_data_i,
    output logic [DATA_W-1:0] pb_data_o,
    output logic              pb_valid_o,
    output logic              ram_en_o,
    output logic              ram_we_o,
    output logic [ADDR_W-1:0] ram_addr_o,
    output logic [DATA_W-1:0] ram_wdata_o,
    input  logic [DATA_W-1:0] ram_rdata_i
);

    localparam int unsigned CNT_W = ADDR_W + 1;

    logic [1:0]       mode_req;
    logic [CNT_W-1:0] count_reg;
    logic             trig;
    logic [2:0]       status;
    mode_state_e      mode_st;
    logic             clr, cap_sel, pb_sel;
    logic [N_SUB-1:0] sub_sel, sub_start, sub_active;
    sub_state_e       sub_st [N_SUB];
    sub_state_e       shown_st;
    logic             last, zero_len;
    logic             pb_valid_q;

    wcap_axil_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
        .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wvalid(s_wvalid), .s_wready(s_wready),
        .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
        .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
        .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
        .status_i(status), .mode_o(mode_req), .count_o(count_reg), .trig_o(trig)
    );

    wcap_mode_fsm u_mode (
        .clk(clk), .rst_n(rst_n), .mode_req_i(mode_req), .state_o(mode_st),
        .clr_o(clr), .cap_sel_o(cap_sel), .pb_sel_o(pb_sel)
    );

    assign sub_sel[SUB_CAP] = cap_sel;
    assign sub_sel[SUB_PB]  = pb_sel;

    for (genvar g = 0; g < N_SUB; g++) begin : g_sub
        wcap_sub_fsm u_sub (
            .clk(clk), .rst_n(rst_n), .clr_i(clr), .sel_i(sub_sel[g]),
            .trig_i(trig), .zero_len_i(zero_len), .last_i(last),
            .state_o(sub_st[g]), .start_o(sub_start[g]), .active_o(sub_active[g])
        );
    end

    wcap_counter #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .start_i(|sub_start),
        .inc_i(|sub_active), .count_i(count_reg), .addr_o(ram_addr_o),
        .last_o(last), .zero_len_o(zero_len)
    );

    assign ram_en_o    = |sub_active;
    assign ram_we_o    = sub_active[SUB_CAP];
    assign ram_wdata_o = cap_data_i;

    always_ff @(posedge clk) begin
        if (!rst_n) pb_valid_q <= 1'b0;
        else        pb_valid_q <= sub_active[SUB_PB];
    end

    assign pb_valid_o = pb_valid_q;
    assign pb_data_o  = pb_valid_q ? ram_rdata_i : '0;

    always_comb begin
        if (cap_sel)     shown_st = sub_st[SUB_CAP];
        else if (pb_sel) shown_st = sub_st[SUB_PB];
        else             shown_st = SUB_IDLE;
        status = {(shown_st == SUB_DONE), shown_st};
    end

endmodule

// File: rtl/wcap_engine_chk.sv
module wcap_engine_chk #(
    parameter int unsigned ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              s_bvalid,
    input logic              s_bready,
    input logic [1:0]        s_bresp,
    input logic              s_rvalid,
    input logic              s_rready,
    input logic [1:0]        s_rresp,
    input logic              ram_en,
    input logic              ram_we,
    input logic [ADDR_W-1:0] ram_addr,
    input logic              pb_valid,
    input logic [1:0]        mode_st,
    input logic [1:0]        cap_st,
    input logic [1:0]        pb_st
);

    p_okay_resp_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (s_bvalid |-> s_bresp == 2'b00) and (s_rvalid |-> s_rresp == 2'b00));

    p_bvalid_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (s_bvalid && !s_bready) |=> s_bvalid);

    p_rvalid_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (s_rvalid && !s_rready) |=> s_rvalid);

    p_single_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(cap_st == 2'd1 && pb_st == 2'd1));

    p_ram_needs_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ram_en |-> mode_st != 2'd0);

    p_write_only_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (ram_en && cap_st == 2'd1));

    p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_en && $past(ram_en)) |-> ram_addr == ADDR_W'($past(ram_addr) + 1'b1));

    p_valid_after_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_en && !ram_we) |=> pb_valid);

    p_valid_has_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pb_valid |-> $past(ram_en && !ram_we));

    p_reset_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_st == 2'd0) |=> (cap_st == 2'd0 && pb_st == 2'd0));

endmodule

bind wcap_engine wcap_engine_chk #(.ADDR_W(ADDR_W)) i_wcap_chk (
    .clk(clk), .rst_n(rst_n),
    .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp),
    .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rresp(s_rresp),
    .ram_en(ram_en_o), .ram_we(ram_we_o), .ram_addr(ram_addr_o),
    .pb_valid(pb_valid_o), .mode_st(mode_st),
    .cap_st(sub_st[0]), .pb_st(sub_st[1])
);

// File: tb/test_wcap_engine.sv
`timescale 1ns/1ps
module test_wcap_engine;

    localparam int DW = 16;
    localparam int AW = 10;
    localparam logic [15:0] SENT = 16'hA5A5;
    // {mode[1:0], count[7:0]}
    localparam logic [9:0] VECS [0:5] = '{
        {2'd1, 8'd5}, {2'd2, 8'd7}, {2'd1, 8'd1},
        {2'd2, 8'd1}, {2'd1, 8'd16}, {2'd2, 8'd12}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    awaddr = '0, araddr = '0;
    logic          awvalid = 0, wvalid = 0, arvalid = 0;
    logic [31:0]   wdata = '0;
    logic          awready, wready, bvalid, arready, rvalid;
    logic [1:0]    bresp, rresp;
    logic [31:0]   rdata;
    logic [DW-1:0] capv = '0, pb_data, ram_wdata;
    logic [DW-1:0] ram_rdata = '0;
    logic          pb_valid, ram_en, ram_we;
    logic [AW-1:0] ram_addr;

    logic [DW-1:0] mem [0:(1<<AW)-1];
    logic          b_we = 0;
    logic [AW-1:0] b_addr = '0;
    logic [DW-1:0] b_data = '0;

    int tests = 0, fails = 0;
    int nwr, nrd, nbeat, first_wr;
    logic [DW-1:0] pbbuf [0:63];

    always #4 clk = ~clk;

    wcap_engine i_wcap_engine (
        .clk(clk), .rst_n(rst_n),
        .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
        .s_wdata(wdata), .s_wstrb(4'hF), .s_wvalid(wvalid), .s_wready(wready),
        .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(1'b1),
        .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
        .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(1'b1),
        .cap_data_i(capv), .pb_data_o(pb_data), .pb_valid_o(pb_valid),
        .ram_en_o(ram_en), .ram_we_o(ram_we), .ram_addr_o(ram_addr),
        .ram_wdata_o(ram_wdata), .ram_rdata_i(ram_rdata)
    );

    // dual-port RAM model: engine port plus a processor-side write port
    always @(posedge clk) begin
        if (ram_en) begin
            if (ram_we) mem[ram_addr] <= ram_wdata;
            else        ram_rdata <= mem[ram_addr];
        end
        if (b_we) mem[b_addr] <= b_data;
    end

    always @(negedge clk) capv <= capv + 1'b1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (ram_en && ram_we) begin
                if (nwr == 0) first_wr = int'(ram_addr);
                nwr++;
            end
            if (ram_en && !ram_we) nrd++;
            if (pb_valid) begin
                if (nbeat < 64) pbbuf[nbeat] = pb_data;
                nbeat++;
            end
        end
    end

    function automatic logic [DW-1:0] pat(input int k);
        return DW'(k * 37 + 5);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic axi_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        awaddr = a; wdata = d; awvalid = 1; wvalid = 1;
        #1;
        while (!awready) begin @(negedge clk); #1; end
        @(negedge clk);
        awvalid = 0; wvalid = 0;
        chk(bvalid && bresp == 2'b00, "R1 bresp", int'(bresp), 0);
    endtask

    task automatic axi_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        araddr = a; arvalid = 1;
        #1;
        while (!arready) begin @(negedge clk); #1; end
        @(negedge clk);
        arvalid = 0;
        d = rdata;
        chk(rvalid && rresp == 2'b00, "R1 rresp", int'(rresp), 0);
    endtask

    task automatic clear_stats();
        @(negedge clk);
        nwr = 0; nrd = 0; nbeat = 0; first_wr = -1;
    endtask

    task automatic preload(input int n, input bit sentinel);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            b_we = 1; b_addr = AW'(k); b_data = sentinel ? SENT : pat(k);
        end
        @(negedge clk);
        b_we = 0;
    endtask

    task automatic wait_done(output logic [31:0] st);
        st = '0;
        for (int i = 0; i < 400; i++) begin
            axi_read(4'h8, st);
            if (st[2]) break;
        end
    endtask

    task automatic run_case(input logic [1:0] mode, input int n);
        logic [31:0] st, rd;
        axi_write(4'h0, {30'd0, mode});
        axi_write(4'h4, n);
        if (mode == 2'd1) preload(n + 2, 1'b1);
        else              preload(n, 1'b0);
        clear_stats();
        axi_write(4'h0, {29'd0, 1'b1, mode});
        wait_done(st);
        repeat (3) @(negedge clk);
        chk(st[2:0] == 3'b110, "R3 done status", int'(st[2:0]), 6);
        if (mode == 2'd1) begin
            chk(nwr == n && first_wr == 0, "R6 write count", nwr, n);
            for (int k = 1; k < n; k++)
                chk(mem[k] == mem[k-1] + 1'b1, "R6 consecutive samples", int'(mem[k]), int'(mem[k-1]) + 1);
            chk(mem[n] == SENT, "R6 word N untouched", int'(mem[n]), int'(SENT));
        end else begin
            chk(nrd == n && nbeat == n, "R7 beat count", nbeat, n);
            for (int k = 0; k < n; k++)
                chk(pbbuf[k] == pat(k), "R7 playback data", int'(pbbuf[k]), int'(pat(k)));
        end
        axi_read(4'h0, rd);
        chk(rd == {30'd0, mode}, "R2 control readback, trigger bit reads 0", int'(rd), int'(mode));
        axi_read(4'h4, rd);
        chk(rd == n, "R2 count readback", int'(rd), n);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] st, rd;
        nwr = 0; nrd = 0; nbeat = 0; first_wr = -1;
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1;

        // reset state
        axi_read(4'h8, st);
        chk(st == 0, "R3 status after reset", int'(st), 0);
        axi_read(4'h0, rd);
        chk(rd == 0, "R2 control after reset", int'(rd), 0);
        axi_read(4'h4, rd);
        chk(rd == 0, "R2 count after reset", int'(rd), 0);

        // trigger in reset mode (R5)
        clear_stats();
        axi_write(4'h4, 8);
        axi_write(4'h0, 32'h4);
        repeat (12) @(negedge clk);
        axi_read(4'h8, st);
        chk(st == 0, "R5 status in reset mode", int'(st), 0);
        chk(nwr == 0 && nrd == 0, "R5 no RAM access", nwr + nrd, 0);

        // table of runs (R4 mode switching between entries, R6, R7)
        for (int v = 0; v < 6; v++)
            run_case(VECS[v][9:8], int'(VECS[v][7:0]));

        // zero count (R8)
        for (int m = 1; m <= 2; m++) begin
            axi_write(4'h0, m);
            axi_write(4'h4, 0);
            clear_stats();
            axi_write(4'h0, 32'(m) | 32'h4);
            repeat (4) @(negedge clk);
            axi_read(4'h8, st);
            chk(st[2:0] == 3'b110, "R8 zero count done", int'(st[2:0]), 6);
            chk(nwr == 0 && nrd == 0 && nbeat == 0, "R8 no RAM access", nwr + nrd, 0);
        end

        // trigger while ACTIVE ignored, trigger in DONE restarts (R9)
        axi_write(4'h0, 1);
        axi_write(4'h4, 60);
        preload(62, 1'b1);
        clear_stats();
        axi_write(4'h0, 32'h5);
        axi_write(4'h0, 32'h5);
        axi_read(4'h8, st);
        chk(st[2:0] == 3'b001, "R9 still ACTIVE", int'(st[2:0]), 1);
        axi_write(4'h4, 3);
        wait_done(st);
        chk(nwr == 60, "R9 retrigger in ACTIVE ignored, count latched", nwr, 60);
        clear_stats();
        axi_write(4'h0, 32'h5);
        wait_done(st);
        chk(nwr == 3 && first_wr == 0, "R9 restart from word 0", first_wr, 0);

        // writes to status and unmapped offset (R3)
        axi_write(4'h8, 32'h0);
        axi_write(4'hC, 32'hFFFF_FFFF);
        axi_read(4'h8, st);
        chk(st[2:0] == 3'b110, "R3 status write ignored", int'(st), 6);
        axi_read(4'hC, rd);
        chk(rd == 0, "R3 unmapped read", int'(rd), 0);
        axi_read(4'h0, rd);
        chk(rd == 1, "R3 unmapped write leaves control", int'(rd), 1);
        axi_read(4'h4, rd);
        chk(rd == 3, "R3 unmapped write leaves count", int'(rd), 3);

        // reset mode clears done (R10)
        axi_write(4'h0, 0);
        axi_read(4'h8, st);
        chk(st == 0, "R10 status in reset mode", int'(st), 0);
        axi_write(4'h0, 1);
        axi_read(4'h8, st);
        chk(st == 0, "R10 capture back to IDLE", int'(st), 0);

        // direct switch capture done -> playback shows IDLE (R4)
        axi_write(4'h0, 5);
        wait_done(st);
        axi_write(4'h0, 2);
        axi_read(4'h8, st);
        chk(st == 0, "R4 playback IDLE after direct switch", int'(st), 0);
        axi_write(4'h0, 1);
        axi_read(4'h8, st);
        chk(st == 0, "R4 capture done cleared by pass through RESET", int'(st), 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule